// File: doc/BRIEF.md
# Strided Vector Address Generator with Interleaved Banks

This block walks through the elements of one vector memory access. A start pulse latches a base address, a stride and an element count. The block then produces one element address after another, each equal to the one before plus the stride. Every address goes out on a single shared request bus, together with its element index and the bank that owns the word.

Words are spread across banks by their low address bits. Each bank is modelled inside the block as a unit with a fixed access time. While a bank is busy it refuses new work, and issue stalls until that bank is free again. The banks return their results on one shared data bus, tagged with the element index, so the caller can write each word into the right slot of a vector register. A one-cycle completion pulse marks the end of the access.

Whether the access runs at full rate depends on the stride. With an odd stride over sixteen banks, and a latency below the bank count, there is one element per cycle. A stride that revisits a bank too soon inserts stall cycles.

Top module: `vec_agen`

## Requirements
- R1: While reset is held and right after it is released, req_valid, rsp_valid, busy and done are all low.
- R2: For a start with base B, stride S and length L>0, the block issues exactly L requests with indices 0..L-1 in rising order. Request i carries address (B + i*S) mod 2^16.
- R3: Each request's bank number equals its address modulo 16, which is the low four address bits.
- R4: At most one request is issued per cycle. The first request is presented in the cycle right after the cycle in which start was sampled, unless that bank is busy.
- R5: A request occupies its bank for 11 cycles. A later request to the same bank is issued no earlier than 11 clock edges after the previous one. While the target bank is busy, issue stalls and the element index does not advance.
- R6: With an odd stride, all L requests are issued on L consecutive cycles.
- R7: A request issued at clock edge E produces a response visible in the cycle that ends at edge E+11. Its data equals the request address XOR 0x5A3C.
- R8: Responses arrive in index order, each carrying the element index of its request.
- R9: done is high for exactly one cycle: the cycle after the last response is seen. busy is low from then on.
- R10: A start with length 0 issues no request and raises done in the cycle after start is sampled.
- R11: Base, stride and length are latched at start. A start pulse or changed inputs during a running access have no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access (ignored while busy) |
| base_addr | input | 16 | Word address of element 0 |
| stride | input | 16 | Word distance between consecutive elements |
| vec_len | input | 7 | Number of elements |
| req_valid | output | 1 | A request is issued this cycle |
| req_addr | output | 16 | Address on the shared bus |
| req_bank | output | 4 | Bank selected by the request |
| req_idx | output | 7 | Element index of the request |
| rsp_valid | output | 1 | A bank returns data this cycle |
| rsp_idx | output | 7 | Element index of the returned data |
| rsp_data | output | 16 | Returned word |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default build: sixteen banks, an 11-cycle access time and 7-bit lengths. With these values the bank count exceeds the latency. Odd strides therefore reach the stall-free rate. Stride 2 touches only eight banks and stalls, stride 16 hits one bank every time, and stride 0 hammers a single address. The bench predicts the exact issue cycle of every element from the per-bank free times. A base near the top of the address space exercises wrap-around, and a negative stride runs the banks backwards.

// File: rtl/vagen_pkg.sv
package vagen_pkg;

    parameter int AW = 16;
    parameter int DW = 16;
    parameter int LW = 7;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] word_t;
    typedef logic [LW-1:0] idx_t;

    typedef enum logic {AG_IDLE, AG_RUN} ag_state_e;

    typedef struct packed {
        logic  valid;
        idx_t  idx;
        word_t data;
    } rsp_t;

    function automatic word_t bank_word(addr_t a, word_t key);
        return word_t'(a) ^ key;
    endfunction

endpackage

// File: rtl/vagen_seq.sv
module vagen_seq
    import vagen_pkg::*;
#(
    parameter int NUM_BANKS = 16,
    localparam int BW = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  addr_t                base_addr,
    input  addr_t                stride,
    input  idx_t                 vec_len,
    input  logic [NUM_BANKS-1:0] bank_free,
    input  logic                 rsp_valid,
    input  idx_t                 rsp_idx,
    output logic                 req_valid,
    output addr_t                req_addr,
    output logic [BW-1:0]        req_bank,
    output idx_t                 req_idx,
    output logic                 busy,
    output logic                 done
);

    ag_state_e state;
    addr_t     cur_addr;
    addr_t     stride_q;
    idx_t      cur_idx;
    idx_t      len_q;

    assign req_addr  = cur_addr;
    assign req_bank  = cur_addr[BW-1:0];
    assign req_idx   = cur_idx;
    assign busy      = (state == AG_RUN);
    assign req_valid = busy && (cur_idx != len_q) && bank_free[req_bank];

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= AG_IDLE;
            cur_addr <= '0;
            stride_q <= '0;
            cur_idx  <= '0;
            len_q    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                AG_IDLE: begin
                    if (start) begin
                        if (vec_len == '0) begin
                            done <= 1'b1;
                        end else begin
                            state    <= AG_RUN;
                            cur_addr <= base_addr;
                            stride_q <= stride;
                            cur_idx  <= '0;
                            len_q    <= vec_len;
                        end
                    end
                end
                default: begin
                    if (req_valid) begin
                        cur_addr <= cur_addr + stride_q;
                        cur_idx  <= cur_idx + idx_t'(1);
                    end
                    if (rsp_valid && rsp_idx == len_q - idx_t'(1)) begin
                        state <= AG_IDLE;
                        done  <= 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/vagen_bank.sv
module vagen_bank
    import vagen_pkg::*;
#(
    parameter int    BANK_LAT = 11,
    parameter word_t DATA_KEY = 16'h5A3C,
    localparam int   CW = $clog2(BANK_LAT + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sel,
    input  addr_t addr,
    input  idx_t  idx,
    output logic  free,
    output rsp_t  cmp
);

    logic [CW-1:0] cnt;
    addr_t         addr_q;
    idx_t          idx_q;

    // The bank may accept new work in the last cycle of its current access.
    assign free       = (cnt <= CW'(1));
    assign cmp.valid  = (cnt == CW'(1));
    assign cmp.idx    = idx_q;
    assign cmp.data   = bank_word(addr_q, DATA_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            addr_q <= '0;
            idx_q  <= '0;
        end else if (sel) begin
            cnt    <= CW'(BANK_LAT);
            addr_q <= addr;
            idx_q  <= idx;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

endmodule

// File: rtl/vagen_rsp_mux.sv
module vagen_rsp_mux
    import vagen_pkg::*;
#(
    parameter int NUM_BANKS = 16
) (
    input  rsp_t [NUM_BANKS-1:0] slots,
    output rsp_t                 bus
);

    // Issue is one per cycle with a fixed latency, so at most one slot completes.
    always_comb begin
        bus = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (slots[i].valid) begin
                bus = rsp_t'(bus | slots[i]);
            end
        end
    end

endmodule

// File: rtl/vec_agen.sv
module vec_agen
    import vagen_pkg::*;
#(
    parameter int    NUM_BANKS = 16,
    parameter int    BANK_LAT  = 11,
    parameter word_t DATA_KEY  = 16'h5A3C,
    localparam int   BW = $clog2(NUM_BANKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] stride,
    input  logic [LW-1:0] vec_len,
    output logic          req_valid,
    output logic [AW-1:0] req_addr,
    output logic [BW-1:0] req_bank,
    output logic [LW-1:0] req_idx,
    output logic          rsp_valid,
    output logic [LW-1:0] rsp_idx,
    output logic [DW-1:0] rsp_data,
    output logic          busy,
    output logic          done
);

    logic [NUM_BANKS-1:0] bank_free;
    rsp_t [NUM_BANKS-1:0] slots;
    rsp_t                 rsp_bus;

    assign rsp_valid = rsp_bus.valid;
    assign rsp_idx   = rsp_bus.idx;
    assign rsp_data  = rsp_bus.data;

    vagen_seq #(.NUM_BANKS(NUM_BANKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .base_addr (base_addr),
        .stride    (stride),
        .vec_len   (vec_len),
        .bank_free (bank_free),
        .rsp_valid (rsp_bus.valid),
        .rsp_idx   (rsp_bus.idx),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_bank  (req_bank),
        .req_idx   (req_idx),
        .busy      (busy),
        .done      (done)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        vagen_bank #(.BANK_LAT(BANK_LAT), .DATA_KEY(DATA_KEY)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .sel  (req_valid && (req_bank == BW'(b))),
            .addr (req_addr),
            .idx  (req_idx),
            .free (bank_free[b]),
            .cmp  (slots[b])
        );
    end

    vagen_rsp_mux #(.NUM_BANKS(NUM_BANKS)) u_mux (
        .slots (slots),
        .bus   (rsp_bus)
    );

endmodule

// File: rtl/vec_agen_chk.sv
module vec_agen_chk
    import vagen_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [AW-1:0] stride,
    input logic [LW-1:0] vec_len,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic [LW-1:0] req_idx,
    input logic          rsp_valid,
    input logic [LW-1:0] rsp_idx,
    input logic          busy,
    input logic          done
);

    idx_t  req_seen;
    idx_t  rsp_seen;
    addr_t last_addr;
    addr_t stride_cap;
    logic  have_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_seen   <= '0;
            rsp_seen   <= '0;
            last_addr  <= '0;
            stride_cap <= '0;
            have_prev  <= 1'b0;
        end else if (!busy) begin
            req_seen  <= '0;
            rsp_seen  <= '0;
            have_prev <= 1'b0;
            if (start) stride_cap <= stride;
        end else begin
            if (req_valid) begin
                req_seen  <= req_seen + idx_t'(1);
                last_addr <= req_addr;
                have_prev <= 1'b1;
            end
            if (rsp_valid) rsp_seen <= rsp_seen + idx_t'(1);
        end
    end

    // R2
    req_order_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_idx == req_seen);

    // R2
    req_stride_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && have_prev) |-> req_addr == last_addr + stride_cap);

    // R8
    rsp_order_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_idx == rsp_seen);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!req_valid && !rsp_valid));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !(start && vec_len == '0)) |=> !done);

endmodule

bind vec_agen vec_agen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .stride    (stride),
    .vec_len   (vec_len),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_idx   (req_idx),
    .rsp_valid (rsp_valid),
    .rsp_idx   (rsp_idx),
    .busy      (busy),
    .done      (done)
);

// File: tb/vec_agen_tb.sv
module vec_agen_tb;
    import vagen_pkg::*;

    localparam int NB  = 16;
    localparam int LAT = 11;
    localparam int KEY = 'h5A3C;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [15:0]   base_addr;
    logic [15:0]   stride;
    logic [6:0]    vec_len;
    logic          req_valid;
    logic [15:0]   req_addr;
    logic [3:0]    req_bank;
    logic [6:0]    req_idx;
    logic          rsp_valid;
    logic [6:0]    rsp_idx;
    logic [15:0]   rsp_data;
    logic          busy;
    logic          done;

    always #10 clk = ~clk;

    vec_agen u_dut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .stride(stride), .vec_len(vec_len), .req_valid(req_valid),
        .req_addr(req_addr), .req_bank(req_bank), .req_idx(req_idx),
        .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
        .busy(busy), .done(done)
    );

    typedef struct {int addr; int idx; int bank; int cyc;} ereq_t;
    typedef struct {int idx; int data; int cyc;} ersp_t;

    ereq_t rq[$];
    ersp_t sq[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int exp_done = -1;
    bit done_seen = 0;
    int nreq, first_req, last_req;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: compare observed traffic against the scoreboard queues.
    always @(negedge clk) begin
        if (!rst) begin
            if (req_valid) begin
                nreq++;
                if (nreq == 1) first_req = cyc;
                last_req = cyc;
                if (rq.size() == 0) begin
                    check(0, "R2 unexpected request idx", req_idx, -1);
                end else begin
                    ereq_t e;
                    e = rq.pop_front();
                    check(req_addr == e.addr, "R2 request address", req_addr, e.addr);
                    check(req_idx == e.idx, "R2 request index", req_idx, e.idx);
                    check(req_bank == e.bank, "R3 request bank", req_bank, e.bank);
                    check(cyc == e.cyc, "R4 R5 request cycle", cyc, e.cyc);
                end
            end
            if (rsp_valid) begin
                if (sq.size() == 0) begin
                    check(0, "R8 unexpected response idx", rsp_idx, -1);
                end else begin
                    ersp_t s;
                    s = sq.pop_front();
                    check(rsp_idx == s.idx, "R8 response index", rsp_idx, s.idx);
                    check(rsp_data == s.data, "R7 response data", rsp_data, s.data);
                    check(cyc == s.cyc, "R7 response cycle", cyc, s.cyc);
                end
            end
            if (done) begin
                check(exp_done >= 0 && cyc == exp_done, "R9 R10 done cycle", cyc, exp_done);
                check(!busy, "R9 busy low with done", busy, 0);
                exp_done  = -1;
                done_seen = 1;
            end
        end
    end

    // Driver: predict the schedule from per-bank free times, then start.
    task automatic run_vec(input int base, input int str, input int len, input bit poke);
        int lastb[NB];
        int s_edge, prev, a, b, e;
        for (int k = 0; k < NB; k++) lastb[k] = -1000;
        while (busy) @(negedge clk);
        @(negedge clk);
        s_edge = cyc + 1;
        prev = s_edge;
        a = base & 'hFFFF;
        for (int i = 0; i < len; i++) begin
            b = a % NB;
            e = prev + 1;
            if (lastb[b] + LAT > e) e = lastb[b] + LAT;
            rq.push_back('{addr: a, idx: i, bank: b, cyc: e - 1});
            sq.push_back('{idx: i, data: (a ^ KEY) & 'hFFFF, cyc: e + LAT - 1});
            lastb[b] = e;
            prev = e;
            a = (a + str) & 'hFFFF;
        end
        exp_done  = (len == 0) ? s_edge : prev + LAT;
        nreq      = 0;
        done_seen = 0;
        base_addr = 16'(base);
        stride    = 16'(str);
        vec_len   = 7'(len);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            base_addr = base_addr ^ 16'h1234;
            stride    = stride + 16'd5;
            vec_len   = 7'd3;
            start     = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done_seen) @(negedge clk);
        @(negedge clk);
        check(rq.size() == 0, poke ? "R11 requests left" : "R2 requests left", rq.size(), 0);
        check(sq.size() == 0, "R8 responses left", sq.size(), 0);
        check(!busy && !done, "R9 idle after done", {busy, done}, 0);
        if (len == 0) check(nreq == 0, "R10 no request on zero length", nreq, 0);
        if (len > 0 && (str % 2) == 1)
            check(last_req - first_req == len - 1, "R6 back-to-back issue", last_req - first_req, len - 1);
        rq.delete();
        sq.delete();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        base_addr = '0;
        stride = '0;
        vec_len = '0;
        repeat (3) @(negedge clk);
        check(!req_valid && !rsp_valid && !busy && !done, "R1 outputs in reset",
              {req_valid, rsp_valid, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!req_valid && !rsp_valid && !busy && !done, "R1 outputs after reset",
              {req_valid, rsp_valid, busy, done}, 0);

        run_vec('h0100, 1, 20, 0);      // unit stride, full rate
        run_vec('hFFF0, 3, 33, 0);      // odd stride wrapping the address space
        run_vec('h0040, 2, 20, 0);      // eight banks only: stalls
        run_vec('h0005, 16, 4, 0);      // single bank every time
        run_vec('h0777, 0, 5, 0);       // same address repeatedly
        run_vec('h0200, 'hFFFF, 18, 0); // negative stride
        run_vec('h0300, 1, 0, 0);       // zero length
        run_vec('h0400, 5, 12, 1);      // start and input changes mid-run
        run_vec('h0010, 7, 64, 0);      // long odd stride run
        finish_run();
    end

endmodule